// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps wall-clock time and date in seven byte-wide packed BCD fields. The fields are seconds, minutes, hours, weekday, day of month, month and a two-digit year. The year value 00 to 99 stands for 2000 to 2099. A fast strobe, `base_tick`, feeds an internal prescaler. Every `PRESCALE` strobes the prescaler makes a one-second step, and that step ripples through the fields with correct wrap-around at every level. The wrap-around covers month lengths and leap-year Februaries.

The hours field has two formats, selected by a mode bit stored in that field:

- With the mode bit clear, hours run 00 to 23.
- With the mode bit set, hours run 12, 01, ..., 11. A PM flag in the same byte flips at the 11-to-12 crossing.

The counter steps correctly in whichever format the stored mode bit selects. A host loads any field through a simple write port and reads any field through a combinational read port. A halt input freezes time completely, as when the oscillator is stopped.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour format), weekday 01, day 01, month 01, year 00.
- R2: While `osc_off` is low, seconds advance by one on the clock edge that samples the `PRESCALE`-th `base_tick` since the prescaler was last cleared; earlier strobes leave the fields unchanged.
- R3: While `osc_off` is high, no `base_tick` changes the prescaler or any field.
- R4: Seconds and minutes count 00 to 59 in BCD (low digit 9 carries into the high digit); at 59 a field returns to 00 and carries into the next field.
- R5: With hour bit 6 clear, hours count 00 to 23 in BCD, and a carry out of 23 returns to 00 and advances the day.
- R6: With hour bit 6 set, bits 4..0 hold the hour 01 to 12 in BCD and bit 5 is the PM flag. The hour goes 12 to 01 with the flag kept, and 11 to 12 with the flag inverted. The day advances only when 11 with the flag set becomes 12.
- R7: On each day advance the weekday counts 1 to 7 and returns from 7 to 1.
- R8: The day of month returns to 01 and carries into the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and in month 02 after day 29 when the year is divisible by 4 and after day 28 otherwise.
- R9: A month carry from 12 returns the month to 01 and advances the year; year 99 advances to 00.
- R10: Field addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year. A write to one of these addresses loads `wr_data` into that field on the next edge, taking precedence over a step to that same field in that cycle. A write to address 7 changes nothing, and reading address 7 returns 00.
- R11: A write to the seconds field clears the prescaler. Any one-second step falling in that same cycle is discarded, so the next step needs a full `PRESCALE` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_off | input | 1 | High halts timekeeping |
| base_tick | input | 1 | Prescaler strobe, one clock wide |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address for a write |
| wr_data | input | 8 | Value to load |
| rd_addr | input | 3 | Field address for the read port |
| rd_data | output | 8 | Selected field, combinational |

## Verification
Every field update is due on the first clock edge after its cause: the edge that samples the last needed `base_tick`, or the edge that samples `wr_en`. No extra pipeline stage sits in either path. The read port is combinational, so a field is visible at `rd_data` as soon as `rd_addr` selects it. The bench drives all inputs on falling edges and samples `rd_data` shortly after a falling edge, always at least half a cycle after the edge that was due to change the value. The prescaler tests count strobes one at a time, so the step is checked both one strobe early (no change) and exactly on time.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NF     = 7;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = $clog2(NF + 1);

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_MDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  // two-digit packed BCD increment, no range check
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return 8'({4'b0, v[7:4]} * 8'd10 + {4'b0, v[3:0]});
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    return (bcd_to_bin(yr) % 8'd4) == 8'd0;
  endfunction

  // last valid day of a month, BCD
  function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // highest value of fields with a fixed range
  function automatic logic [7:0] wrap_limit(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_WDAY:       return 8'h07;
      F_MON:        return 8'h12;
      F_YEAR:       return 8'h99;
      default:      return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wrap_first(input int idx);
    return (idx == F_WDAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] reset_value(input int idx);
    return (idx == F_WDAY || idx == F_MDAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = run_i && base_tick_i && at_last && !clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (run_i && base_tick_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0)); // R11

  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clear_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/cal_wrap_stage.sv
module cal_wrap_stage #(
  parameter logic [7:0] LIMIT = 8'h59,
  parameter logic [7:0] FIRST = 8'h00
) (
  input  logic [7:0] cur_i,
  output logic [7:0] nxt_o,
  output logic       carry_o
);
  import cal_pkg::*;

  assign carry_o = (cur_i >= LIMIT);
  assign nxt_o   = carry_o ? FIRST : bcd_inc(cur_i);

endmodule

// File: rtl/cal_mday_stage.sv
module cal_mday_stage (
  input  logic [7:0] cur_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  output logic [7:0] nxt_o,
  output logic       carry_o
);
  import cal_pkg::*;

  logic [7:0] last_day;

  assign last_day = month_last_day(mon_i, yr_i);
  assign carry_o  = (cur_i >= last_day);
  assign nxt_o    = carry_o ? 8'h01 : bcd_inc(cur_i);

endmodule

// File: rtl/cal_hour_stage.sv
module cal_hour_stage (
  input  logic [6:0] cur_i,
  output logic [6:0] nxt_o,
  output logic       carry_o
);
  logic       twelve;
  logic       pm;
  logic [4:0] h12_inc;
  logic [5:0] h24_inc;

  assign twelve = cur_i[6];
  assign pm     = cur_i[5];

  assign h12_inc = (cur_i[3:0] >= 4'd9) ? {1'b1, 4'd0} : {cur_i[4], cur_i[3:0] + 4'd1};
  assign h24_inc = (cur_i[3:0] >= 4'd9) ? {cur_i[5:4] + 2'd1, 4'd0}
                                        : {cur_i[5:4], cur_i[3:0] + 4'd1};

  always_comb begin
    nxt_o   = '0;
    carry_o = 1'b0;
    if (!twelve) begin
      if (cur_i[5:0] >= 6'h23) begin
        nxt_o   = 7'h00;
        carry_o = 1'b1;
      end else begin
        nxt_o = {1'b0, h24_inc};
      end
    end else begin
      if (cur_i[4:0] >= 5'h12) begin
        nxt_o = {1'b1, pm, 5'h01};
      end else if (cur_i[4:0] == 5'h11) begin
        nxt_o   = {1'b1, !pm, 5'h12};
        carry_o = pm;
      end else begin
        nxt_o = {1'b1, pm, h12_inc};
      end
    end
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_off,
  input  logic       base_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  import cal_pkg::*;

  logic [NF-1:0][BYTE_W-1:0] cal_q;
  logic [BYTE_W-1:0]         adv_val [NF];
  logic                      step    [NF];
  logic                      carry   [NF];
  logic                      sec_tick;
  logic                      sec_wr;

  assign sec_wr = wr_en && (wr_addr == ADDR_W'(F_SEC));

  cal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_tick_i (base_tick),
    .run_i       (!osc_off),
    .clear_i     (sec_wr),
    .tick_o      (sec_tick)
  );

  for (genvar i = 0; i < NF; i++) begin : g_field
    if (i == F_HOUR) begin : g_hour
      logic [6:0] h_nxt;
      cal_hour_stage u_stage (
        .cur_i   (cal_q[i][6:0]),
        .nxt_o   (h_nxt),
        .carry_o (carry[i])
      );
      assign adv_val[i] = {1'b0, h_nxt};
    end else if (i == F_MDAY) begin : g_mday
      cal_mday_stage u_stage (
        .cur_i   (cal_q[i]),
        .mon_i   (cal_q[F_MON]),
        .yr_i    (cal_q[F_YEAR]),
        .nxt_o   (adv_val[i]),
        .carry_o (carry[i])
      );
    end else begin : g_wrap
      cal_wrap_stage #(.LIMIT(wrap_limit(i)), .FIRST(wrap_first(i))) u_stage (
        .cur_i   (cal_q[i]),
        .nxt_o   (adv_val[i]),
        .carry_o (carry[i])
      );
    end

    // carry chain: weekday and day both hang off the hour carry
    if (i == F_SEC) begin : g_s0
      assign step[i] = sec_tick;
    end else if (i == F_MDAY) begin : g_sd
      assign step[i] = step[F_HOUR] && carry[F_HOUR];
    end else begin : g_sn
      assign step[i] = step[i-1] && carry[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) cal_q[i] <= reset_value(i);
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (wr_en && wr_addr == ADDR_W'(i)) cal_q[i] <= wr_data;
        else if (step[i])                   cal_q[i] <= adv_val[i];
      end
    end
  end

  assign rd_data = (rd_addr < ADDR_W'(NF)) ? cal_q[rd_addr] : '0;

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> !osc_off); // R3

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !wr_en) |=> $stable(cal_q)); // R3

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(F_MIN)) |=> (cal_q[F_MIN] == $past(wr_data))); // R10

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step[F_WDAY] && carry[F_WDAY] && !(wr_en && wr_addr == ADDR_W'(F_WDAY)))
      |=> (cal_q[F_WDAY] == 8'h01)); // R7

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step[F_YEAR] && carry[F_YEAR] && !(wr_en && wr_addr == ADDR_W'(F_YEAR)))
      |=> (cal_q[F_YEAR] == 8'h00)); // R9

  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (step[F_HOUR] && cal_q[F_HOUR][6] && cal_q[F_HOUR][4:0] == 5'h11
      && !(wr_en && wr_addr == ADDR_W'(F_HOUR)))
      |=> (cal_q[F_HOUR][5] != $past(cal_q[F_HOUR][5]))); // R6

endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;

  localparam int PRE = 4;
  localparam int NV  = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_off = 1'b0;
  logic       base_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bcd_calendar #(.PRESCALE(PRE)) i_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .osc_off(osc_off), .base_tick(base_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  // preset {sec,min,hour,wday,mday,mon,year} , expected after one second
  localparam logic [111:0] VEC [NV] = '{
    {56'h05_00_00_01_01_01_00, 56'h06_00_00_01_01_01_00},
    {56'h59_12_00_01_01_01_00, 56'h00_13_00_01_01_01_00},
    {56'h59_59_09_02_10_06_30, 56'h00_00_10_02_10_06_30},
    {56'h59_59_23_07_15_03_21, 56'h00_00_00_01_16_03_21},
    {56'h59_59_23_03_31_01_24, 56'h00_00_00_04_01_02_24},
    {56'h59_59_23_03_30_04_24, 56'h00_00_00_04_01_05_24},
    {56'h59_59_23_05_28_02_24, 56'h00_00_00_06_29_02_24},
    {56'h59_59_23_06_29_02_24, 56'h00_00_00_07_01_03_24},
    {56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
    {56'h59_59_23_02_28_02_00, 56'h00_00_00_03_29_02_00},
    {56'h59_59_23_02_28_02_10, 56'h00_00_00_03_01_03_10},
    {56'h59_59_23_04_31_12_99, 56'h00_00_00_05_01_01_00},
    {56'h59_59_51_01_05_05_05, 56'h00_00_72_01_05_05_05},
    {56'h59_59_71_07_05_05_05, 56'h00_00_52_01_06_05_05},
    {56'h59_59_52_01_05_05_05, 56'h00_00_41_01_05_05_05},
    {56'h59_59_72_01_05_05_05, 56'h00_00_61_01_05_05_05},
    {56'h59_59_69_01_05_05_05, 56'h00_00_70_01_05_05_05},
    {56'h59_59_23_02_30_11_19, 56'h00_00_00_03_01_12_19}
  };

  function automatic string vec_req(input int k);
    case (k)
      0, 1:    return "R4";
      2:       return "R5";
      3:       return "R7";
      11:      return "R9";
      12, 13, 14, 15, 16: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input logic [55:0] act, input logic [55:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic rd_all(output logic [55:0] v);
    logic [7:0] b;
    for (int f = 0; f < 7; f++) begin
      rd(3'(f), b);
      v[55-8*f -: 8] = b;
    end
  endtask

  initial begin
    logic [55:0] all_v, before_v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_all(all_v);
    check(all_v, 56'h00_00_00_01_01_01_00, "R1");

    // table walk: preset, one second, compare
    for (int k = 0; k < NV; k++) begin
      for (int f = 0; f < 7; f++) wr(3'(f), VEC[k][111-8*f -: 8]);
      pulse(PRE);
      rd_all(all_v);
      check(all_v, VEC[k][55:0], vec_req(k));
    end

    // R3 halt freezes time and prescaler
    wr(3'd0, 8'h10);
    osc_off = 1'b1;
    pulse(10);
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h10}, "R3");
    osc_off = 1'b0;
    pulse(PRE);
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h11}, "R3");

    // R2 step lands exactly on the PRE-th strobe
    wr(3'd0, 8'h20);
    pulse(PRE - 1);
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h20}, "R2");
    pulse(1);
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h21}, "R2");

    // R11 seconds write restarts the prescaler
    pulse(PRE - 1);
    wr(3'd0, 8'h30);
    pulse(1);
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h30}, "R11");
    pulse(PRE - 2);
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h30}, "R11");
    pulse(1);
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h31}, "R11");

    // R10 write to minutes in the same cycle as a carrying step
    wr(3'd0, 8'h59);
    wr(3'd1, 8'h10);
    pulse(PRE - 1);
    @(negedge clk);
    base_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h40;
    @(negedge clk);
    base_tick = 1'b0; wr_en = 1'b0;
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h00}, "R10");
    rd(3'd1, b); check({48'd0, b}, {48'd0, 8'h40}, "R10");

    // R11 seconds write coinciding with a due step discards the step
    wr(3'd0, 8'h02);
    pulse(PRE - 1);
    @(negedge clk);
    base_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h05;
    @(negedge clk);
    base_tick = 1'b0; wr_en = 1'b0;
    rd(3'd0, b); check({48'd0, b}, {48'd0, 8'h05}, "R11");
    rd(3'd1, b); check({48'd0, b}, {48'd0, 8'h40}, "R11");

    // R10 address 7 is inert
    rd_all(before_v);
    wr(3'd7, 8'h55);
    rd(3'd7, b); check({48'd0, b}, 56'd0, "R10");
    rd_all(all_v);
    check(all_v, before_v, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule